// File: doc/BRIEF.md
# Modem Line Control and Status Registers

This block holds the modem-side control and status registers of a 16550-style serial port. Four external modem lines (clear-to-send, data-set-ready, carrier detect and ring indicator) pass through a synchronizer. Their settled levels are shown in the upper half of the status byte. Each change is latched as a sticky delta flag in the lower half. The ring line is the exception: its flag records only the end of a ring, when the line falls from asserted to deasserted. A status read hands back the current byte and clears the flags.

The control byte drives the request-to-send and data-terminal-ready outputs and also holds two general outputs and a loopback switch. With loopback on, status reads no longer show the external lines. They show the four control outputs, each placed on a fixed status bit. The external request-to-send and data-terminal-ready pins stay frozen at their last values. A modem-status interrupt request is raised while the caller's enable input is high and any delta flag is set. A simple byte port reaches both registers: one select line picks control or status, a write strobe loads control, and a read strobe marks a status read.

Top module: `modem_line_ctrl`

## Requirements
- R1: After reset the control register reads 0x08, rts_out and dtr_out are 0, msi_req is 0 and, with modem_lines_in held at 4'b1011, the status register reads 0xB0.
- R2: Status bits 7..4 show the synchronized modem_lines_in bits 3..0 (bit 3 carrier detect, bit 2 ring, bit 1 data-set-ready, bit 0 clear-to-send), at most SYNC_STAGES+1 clock edges after an input change.
- R3: Status bits 3, 1 and 0 are sticky flags set by any change of line bit 3, 1 and 0 respectively.
- R4: Status bit 2 is set only when the ring line falls from 1 to 0; a rising ring line leaves it unchanged.
- R5: A status read (reg_sel=1, rd_en=1) outside loopback returns the current byte combinationally and clears bits 3..0 at the clock edge that ends the read.
- R6: A delta that arrives at the same edge as a clearing status read is kept set.
- R7: A control write (reg_sel=0, wr_en=1) stores wr_data[4:0]; a control read returns them with bits 7..5 zero.
- R8: With control bit 4 set, status reads return bit7=control bit 3, bit6=control bit 2, bit5=control bit 0, bit4=control bit 1, bits 3..0 zero, and do not clear the stored deltas.
- R9: rts_out takes wr_data[1] and dtr_out takes wr_data[0] on a control write whose bit 4 is 0; a control write with bit 4 set leaves both pins unchanged.
- R10: msi_req is high exactly while msi_enable is high and at least one stored delta flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | 0 selects the control register, 1 the status register |
| wr_en | input | 1 | Write strobe (control register only) |
| rd_en | input | 1 | Read strobe; a status read clears the deltas |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data for the selected register |
| modem_lines_in | input | 4 | Asynchronous modem inputs {carrier, ring, dsr, cts} |
| msi_enable | input | 1 | Modem-status interrupt enable |
| rts_out | output | 1 | Request-to-send output |
| dtr_out | output | 1 | Data-terminal-ready output |
| msi_req | output | 1 | Modem-status interrupt request |

## Verification
The assertions assume that modem_lines_in equals its reset pattern when reset is released, so the synchronizer and the recorded line state start out equal. They also assume that rd_en and wr_en change only away from the rising edge. The bench holds the lines at 4'b1011 through reset and drives every strobe and line change at the falling edge. It then sweeps all 256 old/new line pairs and all 32 control values. A read placed on the edge where a delta lands checks the set-over-clear rule.

// File: rtl/modem_line_pkg.sv
package modem_line_pkg;
   localparam int LINE_N   = 4;
   localparam int LN_CTS   = 0;
   localparam int LN_DSR   = 1;
   localparam int LN_RI    = 2;
   localparam int LN_DCD   = 3;
   localparam int CTRL_W   = 5;
   localparam int CB_DTR   = 0;
   localparam int CB_RTS   = 1;
   localparam int CB_OUT1  = 2;
   localparam int CB_OUT2  = 3;
   localparam int CB_LOOP  = 4;

   typedef enum logic {SEL_CTRL = 1'b0, SEL_STAT = 1'b1} reg_sel_e;

   // Loopback view: control outputs placed onto the line positions.
   function automatic logic [LINE_N-1:0] loop_lines(input logic [CTRL_W-1:0] c);
      logic [LINE_N-1:0] l;
      l[LN_DCD] = c[CB_OUT2];
      l[LN_RI]  = c[CB_OUT1];
      l[LN_DSR] = c[CB_DTR];
      l[LN_CTS] = c[CB_RTS];
      return l;
   endfunction
endpackage

// File: rtl/modem_line_sync.sv
module modem_line_sync #(
   parameter int               WIDTH   = 4,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   logic [WIDTH-1:0] chain_q [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("modem_line_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               chain_q[s] <= RST_VAL;
            else if (s == 0)
               chain_q[s] <= async_in;
            else
               chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/modem_delta_track.sv
module modem_delta_track
   import modem_line_pkg::*;
#(
   parameter logic [LINE_N-1:0] LINE_RST = 4'b1011
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINE_N-1:0] line_sync,
   input  logic              clr_deltas,
   output logic [LINE_N-1:0] line_q,
   output logic [LINE_N-1:0] delta_q
);
   logic [LINE_N-1:0] changed;
   logic [LINE_N-1:0] delta_set;

   assign changed = line_sync ^ line_q;

   generate
      for (genvar b = 0; b < LINE_N; b++) begin : g_bit
         if (b == LN_RI) begin : g_trailing
            assign delta_set[b] = changed[b] & ~line_sync[b];
         end else begin : g_any
            assign delta_set[b] = changed[b];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q  <= LINE_RST;
         delta_q <= '0;
      end else begin
         line_q  <= line_sync;
         delta_q <= (clr_deltas ? '0 : delta_q) | delta_set;
      end
   end
endmodule

// File: rtl/modem_ctrl_reg.sv
module modem_ctrl_reg
   import modem_line_pkg::*;
#(
   parameter logic [CTRL_W-1:0] CTRL_RST = 5'h08
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_wr,
   input  logic [CTRL_W-1:0] ctrl_wdata,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic              rts_out,
   output logic              dtr_out
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= CTRL_RST;
         rts_out <= 1'b0;
         dtr_out <= 1'b0;
      end else if (ctrl_wr) begin
         ctrl_q <= ctrl_wdata;
         if (!ctrl_wdata[CB_LOOP]) begin
            rts_out <= ctrl_wdata[CB_RTS];
            dtr_out <= ctrl_wdata[CB_DTR];
         end
      end
   end
endmodule

// File: rtl/modem_line_ctrl.sv
module modem_line_ctrl
   import modem_line_pkg::*;
#(
   parameter int                DATA_W      = 8,
   parameter int                SYNC_STAGES = 2,
   parameter logic [LINE_N-1:0] LINE_RST    = 4'b1011,
   parameter logic [CTRL_W-1:0] CTRL_RST    = 5'h08
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_sel,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic [LINE_N-1:0] modem_lines_in,
   input  logic              msi_enable,
   output logic              rts_out,
   output logic              dtr_out,
   output logic              msi_req
);
   localparam int STAT_W = 2 * LINE_N;

   generate
      if (DATA_W < STAT_W) begin : g_bad_width
         $error("modem_line_ctrl: DATA_W must be at least 8");
      end
   endgenerate

   logic [LINE_N-1:0] line_sync;
   logic [LINE_N-1:0] line_q;
   logic [LINE_N-1:0] delta_q;
   logic [CTRL_W-1:0] mcr_q;
   logic              loop_on;
   logic              stat_rd;
   logic [STAT_W-1:0] stat_view;

   assign loop_on = mcr_q[CB_LOOP];
   assign stat_rd = rd_en && (reg_sel == SEL_STAT);

   modem_line_sync #(
      .WIDTH   (LINE_N),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (LINE_RST)
   ) sync_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (modem_lines_in),
      .sync_out (line_sync)
   );

   modem_delta_track #(
      .LINE_RST (LINE_RST)
   ) delta_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_sync  (line_sync),
      .clr_deltas (stat_rd && !loop_on),
      .line_q     (line_q),
      .delta_q    (delta_q)
   );

   modem_ctrl_reg #(
      .CTRL_RST (CTRL_RST)
   ) ctrl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl_wr    (wr_en && (reg_sel == SEL_CTRL)),
      .ctrl_wdata (wr_data[CTRL_W-1:0]),
      .ctrl_q     (mcr_q),
      .rts_out    (rts_out),
      .dtr_out    (dtr_out)
   );

   always_comb begin
      if (loop_on)
         stat_view = {loop_lines(mcr_q), {LINE_N{1'b0}}};
      else
         stat_view = {line_q, delta_q};
      rd_data = '0;
      if (reg_sel == SEL_STAT)
         rd_data[STAT_W-1:0] = stat_view;
      else
         rd_data[CTRL_W-1:0] = mcr_q;
   end

   assign msi_req = msi_enable && (|delta_q);
endmodule

// File: rtl/modem_line_ctrl_chk.sv
module modem_line_ctrl_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_sel,
   input logic              wr_en,
   input logic              rd_en,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] rd_data,
   input logic              msi_enable,
   input logic              msi_req,
   input logic              rts_out,
   input logic              dtr_out,
   input logic [3:0]        line_sync,
   input logic [3:0]        line_q,
   input logic [3:0]        delta_q,
   input logic [4:0]        mcr_q
);
   // R4: a rising ring line never sets the trailing-edge flag
   assert_ri_rise_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!line_q[2] && line_sync[2] && !delta_q[2]) |=> !delta_q[2]);

   // R5: a non-loopback status read with no new change leaves no deltas
   assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && reg_sel && !mcr_q[4] && (line_sync == line_q)) |=> (delta_q == 4'b0));

   // R6: a change arriving during a clearing read is kept
   assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && reg_sel && !mcr_q[4] && (line_sync[0] != line_q[0])) |=> delta_q[0]);

   // R7: control reads have zero upper bits
   assert_ctrl_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_sel) |-> (rd_data[7:5] == 3'b0));

   // R8: loopback status reads carry no delta bits and keep stored deltas
   assert_loop_lower_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_sel && mcr_q[4]) |-> (rd_data[3:0] == 4'b0));
   assert_loop_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && reg_sel && mcr_q[4] && !wr_en) |=> ((delta_q & $past(delta_q)) == $past(delta_q)));

   // R9: a loopback control write freezes the modem outputs
   assert_loop_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !reg_sel && wr_data[4]) |=> ($stable(rts_out) && $stable(dtr_out)));

   // R10: request only with enable
   assert_msi_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      msi_req |-> msi_enable);
endmodule

bind modem_line_ctrl modem_line_ctrl_chk #(.DATA_W(DATA_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_sel    (reg_sel),
   .wr_en      (wr_en),
   .rd_en      (rd_en),
   .wr_data    (wr_data),
   .rd_data    (rd_data),
   .msi_enable (msi_enable),
   .msi_req    (msi_req),
   .rts_out    (rts_out),
   .dtr_out    (dtr_out),
   .line_sync  (line_sync),
   .line_q     (line_q),
   .delta_q    (delta_q),
   .mcr_q      (mcr_q)
);

// File: tb/modem_line_ctrl_tb.sv
module modem_line_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_sel = 1'b0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic [3:0] lines = 4'b1011;
   logic       msi_enable = 1'b0;
   logic       rts_out, dtr_out, msi_req;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;
   logic rts_m = 1'b0;
   logic dtr_m = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   modem_line_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
      .wr_data(wr_data), .rd_data(rd_data), .modem_lines_in(lines),
      .msi_enable(msi_enable), .rts_out(rts_out), .dtr_out(dtr_out), .msi_req(msi_req)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic rd(input logic sel, output logic [7:0] val);
      @(negedge clk);
      reg_sel = sel;
      rd_en = 1'b1;
      #1 val = rd_data;
      @(posedge clk);
      #1 rd_en = 1'b0;
   endtask

   task automatic wr_ctrl(input logic [7:0] v);
      @(negedge clk);
      reg_sel = 1'b0;
      wr_data = v;
      wr_en = 1'b1;
      @(posedge clk);
      #1 wr_en = 1'b0;
      if (!v[4]) begin
         rts_m = v[1];
         dtr_m = v[0];
      end
   endtask

   task automatic set_lines(input logic [3:0] v);
      @(negedge clk);
      lines = v;
      repeat (4) @(posedge clk);
   endtask

   function automatic logic [3:0] exp_delta(input logic [3:0] o, input logic [3:0] n);
      logic [3:0] d;
      d = o ^ n;
      d[2] = o[2] & ~n[2];
      return d;
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      logic [3:0] d;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      repeat (4) @(posedge clk);

      // R1 reset state
      rd(1'b0, v); check("R1 ctrl", v, 8'h08);
      rd(1'b1, v); check("R1 status", v, 8'hB0);
      check("R1 rts/dtr/msi", {5'b0, rts_out, dtr_out, msi_req}, 8'h00);

      // R2 R3 R4 R5 R10 exhaustive line transitions
      for (int o = 0; o < 16; o++) begin
         for (int n = 0; n < 16; n++) begin
            set_lines(o[3:0]);
            rd(1'b1, v);
            set_lines(n[3:0]);
            d = exp_delta(o[3:0], n[3:0]);
            @(negedge clk) msi_enable = (o + n) % 2 == 0;
            #1 check("R10 msi_req", {7'b0, msi_req}, {7'b0, msi_enable & (|d)});
            rd(1'b1, v);
            check("R2 R3 R4 status after change", v, {n[3:0], d});
            rd(1'b1, v);
            check("R5 deltas cleared", v, {n[3:0], 4'b0});
         end
      end
      msi_enable = 1'b0;

      // R6 delta landing on the clearing edge is kept
      set_lines(4'b0000);
      rd(1'b1, v);
      @(negedge clk) lines = 4'b0001;
      @(posedge clk);
      @(posedge clk);
      rd(1'b1, v);
      check("R6 read before set", v, 8'h00);
      rd(1'b1, v);
      check("R6 delta kept", v, 8'h11);

      // R7 R8 R9 control sweep including loopback
      for (int c = 0; c < 32; c++) begin
         wr_ctrl({3'b111, c[4:0]});
         rd(1'b0, v);
         check("R7 ctrl readback", v, {3'b0, c[4:0]});
         check("R9 rts/dtr", {6'b0, rts_out, dtr_out}, {6'b0, rts_m, dtr_m});
         if (c[4]) begin
            rd(1'b1, v);
            check("R8 loop view", v, {c[3], c[2], c[0], c[1], 4'b0});
         end
      end

      // R8 loopback read leaves deltas intact
      wr_ctrl(8'h00);
      set_lines(4'b0000);
      rd(1'b1, v);
      set_lines(4'b1000);
      wr_ctrl(8'h1C);
      rd(1'b1, v);
      check("R8 loop read", v, 8'hC0);
      wr_ctrl(8'h03);
      check("R9 exit loop outputs", {6'b0, rts_out, dtr_out}, 8'h03);
      rd(1'b1, v);
      check("R8 delta survives loop read", v, 8'h88);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule